// File: doc/BRIEF.md
# Three-Read One-Write Register File with Observation Port

This block holds the general-purpose registers of a small 16-bit processor: sixteen words of 16 bits kept in one indexed storage array. Two read ports supply the operands of an arithmetic or logic operation. One write port stores a result on the rising clock edge. A third read port is steered by a separate 4-bit selector, so that any register can be watched from outside the core at any time, for example on a board display.

All reads are combinational, so an address change shows on the matching data output in the same cycle. A write becomes visible on the edge that stores it, which means a read of the register being written returns the old contents until that edge. An active-low asynchronous reset sets every register to zero.

Top module: `rf_multiport`

## Requirements
- R1: While rstN is low, and after it is released until the first write, every register reads as zero on all three read ports.
- R2: On a rising clk edge with wrEn high, wrData is stored in the register numbered wrAddr (register n is wrAddr == n, 0 to 15).
- R3: On a rising clk edge with wrEn low, no register changes.
- R4: rdDataA shows the current contents of register rdAddrA, combinationally, in the same cycle.
- R5: rdDataB shows the current contents of register rdAddrB, independently of port A.
- R6: peekData shows the current contents of register peekSel at all times, independently of the operand ports.
- R7: A read of the register being written in the same cycle returns the old value; the new value appears after the write edge.
- R8: All three read ports may address the same register at once, and then all three show the same value.
- R9: A write changes only the addressed register; the other fifteen keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset, clears all registers |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 4 | Register number to write |
| wrData | input | 16 | Word to write |
| rdAddrA | input | 4 | Register number for operand port A |
| rdDataA | output | 16 | Operand A contents |
| rdAddrB | input | 4 | Register number for operand port B |
| rdDataB | output | 16 | Operand B contents |
| peekSel | input | 4 | Register number for the observation port |
| peekData | output | 16 | Observation port contents |

## Verification
The case of interest is a write and a read that target the same register in the same cycle. The bench drives all three read addresses onto the register being written before the edge, checks that each port still shows the old word, then checks after the edge that all three show the new word and that the other registers, scanned through the observation port, kept their contents. Random traffic then mixes write-enable, matching and differing addresses, and a reference array in the bench is compared with every port on every cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_WORDS  = 16;
  localparam int RF_WIDTH  = 16;
  localparam int RF_AW     = $clog2(RF_WORDS);
  localparam int RF_RPORTS = 3;

  // Strobes handed from the control side to the storage side.
  typedef struct packed {
    logic [RF_WORDS-1:0] rowWe;
  } rfStrobe_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
(
  input  logic             wrEn,
  input  logic [RF_AW-1:0] wrAddr,
  output rfStrobe_t        strobe
);
  // One-hot row enable from the write address.
  always_comb begin
    for (int r = 0; r < RF_WORDS; r++) begin
      strobe.rowWe[r] = wrEn && (wrAddr == RF_AW'(r));
    end
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int DATA_W = RF_WIDTH
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  rfStrobe_t                          strobe,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic [RF_RPORTS-1:0][RF_AW-1:0]    rdAddr,
  output logic [RF_RPORTS-1:0][DATA_W-1:0]   rdData
);
  logic [DATA_W-1:0] mem [RF_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < RF_WORDS; r++) mem[r] <= '0;
    end else begin
      for (int r = 0; r < RF_WORDS; r++) begin
        if (strobe.rowWe[r]) mem[r] <= wrData;
      end
    end
  end

  // Independent combinational read ports, one mux each.
  for (genvar p = 0; p < RF_RPORTS; p++) begin : g_rd
    assign rdData[p] = mem[rdAddr[p]];
  end
endmodule

// File: rtl/rf_multiport.sv
module rf_multiport
  import rf_pkg::*;
#(
  parameter int DATA_W = RF_WIDTH,
  parameter int ADDR_W = RF_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [ADDR_W-1:0] peekSel,
  output logic [DATA_W-1:0] peekData
);
  rfStrobe_t                           strobe;
  logic [RF_RPORTS-1:0][RF_AW-1:0]     rdAddr;
  logic [RF_RPORTS-1:0][DATA_W-1:0]    rdData;

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdAddr[2] = peekSel;

  rf_ctrl ctrl_i (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  rf_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  assign rdDataA  = rdData[0];
  assign rdDataB  = rdData[1];
  assign peekData = rdData[2];
endmodule

// File: rtl/rf_multiport_chk.sv
module rf_multiport_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic [ADDR_W-1:0] peekSel,
  input logic [DATA_W-1:0] peekData
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (rdDataA == '0 && rdDataB == '0 && peekData == '0));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(wrEn) && rdAddrA == $past(wrAddr)) |-> rdDataA == $past(wrData));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(wrEn) && $stable(rdAddrB)) |-> $stable(rdDataB));

  assert_same_reg_agree_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == rdAddrB && rdAddrA == peekSel) |-> (rdDataA == rdDataB && rdDataB == peekData));

  assert_others_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(wrEn) && $past(wrAddr) != peekSel && $stable(peekSel)) |-> $stable(peekData));
endmodule

bind rf_multiport rf_multiport_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/rf_multiport_tb.sv
`timescale 1ns/1ps
module rf_multiport_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0, rdAddrA = '0, rdAddrB = '0, peekSel = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdDataA, rdDataB, peekData;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [16];

  always #2 clk = ~clk;

  rf_multiport dut_i (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle after a falling edge, compare ports before the rising edge,
  // then update the reference after the rising edge.
  task automatic cycle(logic we, logic [3:0] wa, logic [15:0] wd,
                       logic [3:0] ra, logic [3:0] rb, logic [3:0] ps);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd;
    rdAddrA = ra; rdAddrB = rb; peekSel = ps;
    #1;
    check((we && ra == wa) ? "R7" : "R4", rdDataA, model[ra]);
    check((we && rb == wa) ? "R7" : "R5", rdDataB, model[rb]);
    check((ra == rb && rb == ps) ? "R8" : "R6", peekData, model[ps]);
    @(posedge clk);
    if (we) model[wa] = wd;
  endtask

  task automatic scan(string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wrEn = 1'b0; peekSel = 4'(i);
      #1 check(req, peekData, model[i]);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 check("R1", rdDataA, 16'h0);
    @(negedge clk) rstN = 1'b1;
    scan("R1");

    // R2: fill every register, then read back through the observation port
    for (int i = 0; i < 16; i++) cycle(1'b1, 4'(i), 16'h1111 * 16'(i) ^ 16'hA5C3, 4'(i), 4'(15 - i), 4'(i));
    scan("R2");

    // R3: writes disabled, data presented but must not land
    for (int i = 0; i < 16; i++) cycle(1'b0, 4'(i), 16'hDEAD, 4'(i), 4'(i), 4'(i));
    scan("R3");

    // R7 and R8: all ports on the register under write
    for (int i = 0; i < 16; i += 3) begin
      cycle(1'b1, 4'(i), 16'h7000 + 16'(i), 4'(i), 4'(i), 4'(i));
      cycle(1'b0, 4'(i), 16'h0, 4'(i), 4'(i), 4'(i));
    end
    // R9: single write then full scan
    cycle(1'b1, 4'd9, 16'hBEEF, 4'd0, 4'd1, 4'd2);
    scan("R9");

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      logic [3:0] wa;
      wa = 4'($urandom_range(0, 15));
      cycle(1'($urandom_range(0, 1)), wa, 16'($urandom),
            ($urandom_range(0, 3) == 0) ? wa : 4'($urandom_range(0, 15)),
            ($urandom_range(0, 3) == 0) ? wa : 4'($urandom_range(0, 15)),
            4'($urandom_range(0, 15)));
    end

    // R1: asynchronous clear mid-run, between edges
    @(negedge clk);
    wrEn = 1'b0;
    rstN = 1'b0;
    #0.5;
    for (int i = 0; i < 16; i++) model[i] = '0;
    peekSel = 4'd9; rdAddrA = 4'd3; rdAddrB = 4'd15;
    #0.2;
    check("R1", peekData, 16'h0);
    check("R1", rdDataA, 16'h0);
    check("R1", rdDataB, 16'h0);
    @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    scan("R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule